// File: doc/BRIEF.md
# Ping-Pong Management Command Responder

This block serves management commands that a host places in a single command register, one command at a time. Each command asks for buffers from a numbered pool or queries the state of a pool. The block hands these requests to an external pool-storage model, gathers what the model returns, and writes the result into one of two response registers. The two registers are used in strict alternation. The register that is not currently active shows an all-zero verb until its next result lands.

The block does not use a doorbell to detect a new command. A command is new when its phase bit, bit 7 of the command verb, equals the phase the responder expects. After each completed command the expected phase inverts, and the active response register swaps with it. At reset the command register holds a phase equal to the parameter `RST_PHASE`, and the expected phase is its complement. So with `RST_PHASE` set, the first result goes to response register 0. In general, a command sent with phase p is answered in response register p. Software polls that register's verb until it turns non-zero.

Requests to the pool model and the buffers coming back from it are valid/ready streams. A request holds its valid signal and its fields steady until the model accepts it. The block raises `pool_rsp_ready` only while it is gathering a reply, and it takes one beat per cycle. Each reply ends with a beat that has `last` set.

Top module: `mcr_responder`

## Requirements
- R1: After reset, both response verbs read 0x00 and the command verb reads back as {RST_PHASE, 7'b0}. No pool request is pending.
- R2: A command whose phase bit differs from the expected phase is ignored. It raises no pool request and leaves both response verbs unchanged. This includes a command left in the register from before, or written again with the phase already used.
- R3: An acquire sets verb bits 6:4 = 3'b001 and a count in bits 3:0 of 1 to 8, with a pool byte of 0 to 63. It raises a request with kind 0, the pool ID and the count. The request stays valid, with all its fields stable, until the model accepts it.
- R4: An acquire result has the verb {phase, 3'b001, n}. Here n is the number of buffer beats received, capped at the requested count, and it may be below that count. Descriptor slots 0 to n-1 hold the buffers in the order they arrived.
- R5: An acquire from an empty pool, answered by a single beat flagged `none`, completes with a count of 0 and does not stall.
- R6: A query (bits 6:4 = 3'b100) raises a request with kind 1. It completes with the verb {phase, 3'b100, 0000}, and descriptor slot 0 holds the data word the model returned.
- R7: Any other command code, an acquire count of 0 or above 8, or a pool byte above 63 completes with the verb {phase, 3'b110, 0000} and raises no pool request.
- R8: If any beat of the model's reply has `err` set, the result is {phase, 3'b111, 0000}.
- R9: A command with phase p is answered in response register p. After each completion the expected phase inverts.
- R10: Writing a result into one response register clears the other register's verb to 0x00, so at most one verb is non-zero at a time.
- R11: The pool byte of each response echoes the pool byte of its command.
- R12: While a command is still in progress, the active register's verb reads 0x00. It becomes non-zero only after the final beat has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_verb_in | input | 8 | Command verb: phase[7], code[6:4], count[3:0] |
| cmd_pool_in | input | 8 | Command pool byte |
| cmd_verb_rd | output | 8 | Current command-register verb |
| rd_sel | input | 1 | Response register to read |
| rd_slot | input | 3 | Descriptor slot to read |
| rd_verb | output | 8 | Verb of the selected response register |
| rd_pool | output | 8 | Pool byte of the selected response register |
| rd_desc | output | 64 | Selected descriptor |
| pool_req_valid | output | 1 | Pool request valid |
| pool_req_ready | input | 1 | Pool model accepts the request |
| pool_req_kind | output | 1 | 0 = acquire, 1 = query |
| pool_req_id | output | 6 | Pool ID |
| pool_req_count | output | 4 | Number of buffers requested |
| pool_rsp_valid | input | 1 | Reply beat valid |
| pool_rsp_ready | output | 1 | Block accepts a reply beat |
| pool_rsp_data | input | 64 | Buffer descriptor or query word |
| pool_rsp_none | input | 1 | Beat carries no buffer |
| pool_rsp_err | input | 1 | Beat reports a storage error |
| pool_rsp_last | input | 1 | Final beat of the reply |

## Verification
The hardest case to reach from the ports is a stale command. This is a command register whose contents already match a finished command, together with a host write that repeats the phase just used. Either case should be ignored even though the register holds a well-formed command. The stimulus reaches this by running a full alternating sequence and then writing the last command again unchanged. It also writes a wrong-phase command straight after reset. Each time it watches for a pool request and for any change in either verb. The in-progress zero verb is caught by reading the active register just before the final reply beat is driven. Short and empty pools are produced by a pool model that delivers fewer beats than were requested.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam logic [2:0] OP_ACQ = 3'd1;
  localparam logic [2:0] OP_QRY = 3'd4;
  localparam logic [2:0] OP_BAD = 3'd6;
  localparam logic [2:0] OP_ECC = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_COLLECT = 2'd2,
    ST_COMMIT  = 2'd3
  } mcr_state_e;
endpackage

// File: rtl/mcr_cmd_track.sv
module mcr_cmd_track #(
  parameter logic RST_PHASE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_verb,
  input  logic [7:0] wr_pool,
  input  logic       advance,
  output logic [7:0] verb_q,
  output logic [7:0] pool_q,
  output logic       exp_phase,
  output logic       fire
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verb_q <= {RST_PHASE, 7'b0};
      pool_q <= '0;
    end else if (wr_en) begin
      verb_q <= wr_verb;
      pool_q <= wr_pool;
    end
  end

  // expected phase doubles as the active response index
  always_ff @(posedge clk) begin
    if (!rst_n)       exp_phase <= ~RST_PHASE;
    else if (advance) exp_phase <= ~exp_phase;
  end

  assign fire = (verb_q[7] == exp_phase);
endmodule

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int POOL_W = 6
) (
  input  logic [7:0] verb,
  input  logic [7:0] pool,
  output logic       ok,
  output logic       is_query
);
  logic [2:0] op;
  logic [3:0] cnt;
  logic       pool_ok, cnt_ok, is_acq;

  always_comb begin
    op       = verb[6:4];
    cnt      = verb[3:0];
    pool_ok  = ((pool >> POOL_W) == 8'd0);
    cnt_ok   = (cnt != 4'd0) && (int'(cnt) <= NSLOT);
    is_acq   = (op == OP_ACQ);
    is_query = (op == OP_QRY);
    ok       = pool_ok && (is_query || (is_acq && cnt_ok));
  end
endmodule

// File: rtl/mcr_rsp_entry.sv
module mcr_rsp_entry #(
  parameter int NSLOT  = 8,
  parameter int DESC_W = 64,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mine,
  input  logic              desc_we,
  input  logic [SLOT_W-1:0] desc_slot,
  input  logic [DESC_W-1:0] desc_data,
  input  logic              commit,
  input  logic [7:0]        commit_verb,
  input  logic [7:0]        commit_pool,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [7:0]        verb_o,
  output logic [7:0]        pool_o,
  output logic [DESC_W-1:0] desc_o
);
  logic [DESC_W-1:0] desc_q [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verb_o <= '0;
      pool_o <= '0;
    end else if (commit) begin
      verb_o <= mine ? commit_verb : 8'h00;
      if (mine) pool_o <= commit_pool;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) desc_q[s] <= '0;
    end else if (desc_we && mine) begin
      desc_q[desc_slot] <= desc_data;
    end
  end

  assign desc_o = desc_q[rd_slot];
endmodule

// File: rtl/mcr_rsp_bank.sv
module mcr_rsp_bank #(
  parameter int NSLOT  = 8,
  parameter int DESC_W = 64,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              desc_we,
  input  logic [SLOT_W-1:0] desc_slot,
  input  logic [DESC_W-1:0] desc_data,
  input  logic              commit,
  input  logic [7:0]        commit_verb,
  input  logic [7:0]        commit_pool,
  input  logic              rd_sel,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [7:0]        rd_verb,
  output logic [7:0]        rd_pool,
  output logic [DESC_W-1:0] rd_desc,
  output logic [1:0]        live
);
  logic [7:0]        e_verb [2];
  logic [7:0]        e_pool [2];
  logic [DESC_W-1:0] e_desc [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    mcr_rsp_entry #(.NSLOT(NSLOT), .DESC_W(DESC_W), .SLOT_W(SLOT_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .mine(act == 1'(g)),
      .desc_we(desc_we), .desc_slot(desc_slot), .desc_data(desc_data),
      .commit(commit), .commit_verb(commit_verb), .commit_pool(commit_pool),
      .rd_slot(rd_slot),
      .verb_o(e_verb[g]), .pool_o(e_pool[g]), .desc_o(e_desc[g])
    );
    assign live[g] = |e_verb[g];
  end

  assign rd_verb = e_verb[rd_sel];
  assign rd_pool = e_pool[rd_sel];
  assign rd_desc = e_desc[rd_sel];
endmodule

// File: rtl/mcr_responder.sv
module mcr_responder
  import mcr_pkg::*;
#(
  parameter int   NSLOT     = 8,
  parameter int   DESC_W    = 64,
  parameter int   POOL_W    = 6,
  parameter logic RST_PHASE = 1'b1,
  localparam int  SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int  CNT_W     = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_verb_in,
  input  logic [7:0]        cmd_pool_in,
  output logic [7:0]        cmd_verb_rd,
  input  logic              rd_sel,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [7:0]        rd_verb,
  output logic [7:0]        rd_pool,
  output logic [DESC_W-1:0] rd_desc,
  output logic              pool_req_valid,
  input  logic              pool_req_ready,
  output logic              pool_req_kind,
  output logic [POOL_W-1:0] pool_req_id,
  output logic [3:0]        pool_req_count,
  input  logic              pool_rsp_valid,
  output logic              pool_rsp_ready,
  input  logic [DESC_W-1:0] pool_rsp_data,
  input  logic              pool_rsp_none,
  input  logic              pool_rsp_err,
  input  logic              pool_rsp_last
);
  logic [7:0]  trk_verb, trk_pool;
  logic        exp_phase, fire, dec_ok, dec_query;
  logic        commit;
  logic [7:0]  commit_verb;
  logic [1:0]  live;

  mcr_state_e  state_q;
  logic        kind_q, phase_q, err_q;
  logic [7:0]  pool_q;
  logic [3:0]  req_q;
  logic [2:0]  code_q;
  logic [CNT_W-1:0]  got_q;
  logic        beat, take_buf, desc_we;
  logic [SLOT_W-1:0] desc_slot;

  mcr_cmd_track #(.RST_PHASE(RST_PHASE)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd_we), .wr_verb(cmd_verb_in), .wr_pool(cmd_pool_in),
    .advance(commit),
    .verb_q(trk_verb), .pool_q(trk_pool),
    .exp_phase(exp_phase), .fire(fire)
  );

  mcr_decode #(.NSLOT(NSLOT), .POOL_W(POOL_W)) u_decode (
    .verb(trk_verb), .pool(trk_pool), .ok(dec_ok), .is_query(dec_query)
  );

  assign cmd_verb_rd = trk_verb;

  always_comb begin
    beat      = (state_q == ST_COLLECT) && pool_rsp_valid;
    take_buf  = beat && !pool_rsp_err && !pool_rsp_none &&
                (kind_q || (int'(got_q) < int'(req_q)));
    desc_we   = take_buf;
    desc_slot = kind_q ? '0 : got_q[SLOT_W-1:0];
    commit    = (state_q == ST_COMMIT);
    commit_verb = {phase_q, code_q,
                   (code_q == OP_ACQ) ? 4'(got_q) : 4'd0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      pool_q  <= '0;
      req_q   <= '0;
      code_q  <= '0;
      got_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fire) begin
          pool_q  <= trk_pool;
          phase_q <= trk_verb[7];
          req_q   <= trk_verb[3:0];
          kind_q  <= dec_query;
          got_q   <= '0;
          err_q   <= 1'b0;
          if (dec_ok) begin
            state_q <= ST_ISSUE;
          end else begin
            code_q  <= OP_BAD;
            state_q <= ST_COMMIT;
          end
        end
        ST_ISSUE: if (pool_req_ready) state_q <= ST_COLLECT;
        ST_COLLECT: if (beat) begin
          if (pool_rsp_err) err_q <= 1'b1;
          if (take_buf && !kind_q) got_q <= got_q + 1'b1;
          if (pool_rsp_last) begin
            code_q  <= (err_q || pool_rsp_err) ? OP_ECC :
                       (kind_q ? OP_QRY : OP_ACQ);
            state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pool_req_valid = (state_q == ST_ISSUE);
  assign pool_req_kind  = kind_q;
  assign pool_req_id    = pool_q[POOL_W-1:0];
  assign pool_req_count = req_q;
  assign pool_rsp_ready = (state_q == ST_COLLECT);

  mcr_rsp_bank #(.NSLOT(NSLOT), .DESC_W(DESC_W), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .act(exp_phase),
    .desc_we(desc_we), .desc_slot(desc_slot), .desc_data(pool_rsp_data),
    .commit(commit), .commit_verb(commit_verb), .commit_pool(pool_q),
    .rd_sel(rd_sel), .rd_slot(rd_slot),
    .rd_verb(rd_verb), .rd_pool(rd_pool), .rd_desc(rd_desc),
    .live(live)
  );
endmodule

// File: rtl/mcr_responder_chk.sv
module mcr_responder_chk #(
  parameter int NSLOT  = 8,
  parameter int POOL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pool_req_valid,
  input logic              pool_req_ready,
  input logic              pool_req_kind,
  input logic [POOL_W-1:0] pool_req_id,
  input logic [3:0]        pool_req_count,
  input logic              pool_rsp_ready,
  input logic              commit,
  input logic [7:0]        commit_verb,
  input logic              exp_phase,
  input logic [1:0]        live
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pool_req_valid && !pool_req_ready |=> pool_req_valid &&
    $stable(pool_req_kind) && $stable(pool_req_id) && $stable(pool_req_count));

  a_r12_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !(pool_req_valid && pool_rsp_ready));

  a_r9_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> exp_phase != $past(exp_phase));

  a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(exp_phase));

  a_r9_phase_match: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> commit_verb[7] == exp_phase);

  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> int'(commit_verb[3:0]) <= NSLOT);

  a_r10_single_live: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(live) <= 1);

  a_r10_clear_other: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live == (2'b01 << $past(exp_phase)));
endmodule

bind mcr_responder mcr_responder_chk #(.NSLOT(NSLOT), .POOL_W(POOL_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .pool_req_valid(pool_req_valid), .pool_req_ready(pool_req_ready),
  .pool_req_kind(pool_req_kind), .pool_req_id(pool_req_id),
  .pool_req_count(pool_req_count), .pool_rsp_ready(pool_rsp_ready),
  .commit(commit), .commit_verb(commit_verb),
  .exp_phase(exp_phase), .live(live)
);

// File: tb/mcr_responder_tb_top.sv
`timescale 1ns/1ps
module mcr_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_verb_in = '0, cmd_pool_in = '0, cmd_verb_rd;
  logic        rd_sel = 1'b0;
  logic [2:0]  rd_slot = '0;
  logic [7:0]  rd_verb, rd_pool;
  logic [63:0] rd_desc;
  logic        pool_req_valid, pool_req_ready = 1'b0, pool_req_kind;
  logic [5:0]  pool_req_id;
  logic [3:0]  pool_req_count;
  logic        pool_rsp_valid = 1'b0, pool_rsp_ready;
  logic [63:0] pool_rsp_data = '0;
  logic        pool_rsp_none = 1'b0, pool_rsp_err = 1'b0, pool_rsp_last = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mcr_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_verb_in(cmd_verb_in),
    .cmd_pool_in(cmd_pool_in), .cmd_verb_rd(cmd_verb_rd),
    .rd_sel(rd_sel), .rd_slot(rd_slot), .rd_verb(rd_verb), .rd_pool(rd_pool),
    .rd_desc(rd_desc), .pool_req_valid(pool_req_valid),
    .pool_req_ready(pool_req_ready), .pool_req_kind(pool_req_kind),
    .pool_req_id(pool_req_id), .pool_req_count(pool_req_count),
    .pool_rsp_valid(pool_rsp_valid), .pool_rsp_ready(pool_rsp_ready),
    .pool_rsp_data(pool_rsp_data), .pool_rsp_none(pool_rsp_none),
    .pool_rsp_err(pool_rsp_err), .pool_rsp_last(pool_rsp_last)
  );

  typedef struct packed {
    logic [2:0] code;
    logic [3:0] cnt;
    logic [7:0] pool;
    logic [3:0] avail;
    logic       err;
    logic [2:0] xcode;
    logic [3:0] xcnt;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{3'd1, 4'd1, 8'd5,  4'd8, 1'b0, 3'd1, 4'd1},  // R3 R4 single
    '{3'd1, 4'd8, 8'd63, 4'd8, 1'b0, 3'd1, 4'd8},  // R4 full, top pool
    '{3'd1, 4'd4, 8'd2,  4'd2, 1'b0, 3'd1, 4'd2},  // R4 short
    '{3'd1, 4'd3, 8'd7,  4'd0, 1'b0, 3'd1, 4'd0},  // R5 empty
    '{3'd4, 4'd0, 8'd9,  4'd6, 1'b0, 3'd4, 4'd0},  // R6 query
    '{3'd2, 4'd1, 8'd1,  4'd0, 1'b0, 3'd6, 4'd0},  // R7 bad code
    '{3'd1, 4'd0, 8'd1,  4'd0, 1'b0, 3'd6, 4'd0},  // R7 zero count
    '{3'd1, 4'd9, 8'd1,  4'd0, 1'b0, 3'd6, 4'd0},  // R7 count 9
    '{3'd1, 4'd2, 8'd64, 4'd0, 1'b0, 3'd6, 4'd0},  // R7 pool 64
    '{3'd1, 4'd2, 8'd1,  4'd4, 1'b1, 3'd7, 4'd0},  // R8 acquire error
    '{3'd4, 4'd0, 8'd3,  4'd2, 1'b1, 3'd7, 4'd0},  // R8 query error
    '{3'd1, 4'd8, 8'd0,  4'd5, 1'b0, 3'd1, 4'd5}   // R4 short, pool 0
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, input logic [2:0] slot);
    rd_sel = sel; rd_slot = slot; #1;
  endtask

  task automatic write_cmd(input logic [7:0] v, input logic [7:0] p);
    @(negedge clk); cmd_we = 1'b1; cmd_verb_in = v; cmd_pool_in = p;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic quiet(input int n, input string req, input logic [7:0] v0,
                       input logic [7:0] v1);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pool_req_valid) seen = 1'b1;
    end
    check(!seen, req, seen, 0);
    rd(1'b0, 3'd0); check(rd_verb == v0, req, rd_verb, v0);
    rd(1'b1, 3'd0); check(rd_verb == v1, req, rd_verb, v1);
  endtask

  task automatic run_vec(input vec_t t, input logic ph);
    bit found = 1'b0;
    int k, nb;
    logic [7:0] xv;
    if (t.xcode != 3'd6) begin
      for (int i = 0; i < 20 && !found; i++) begin
        @(negedge clk);
        if (pool_req_valid) found = 1'b1;
      end
      check(found && pool_req_kind == (t.code == 3'd4) &&
            pool_req_id == t.pool[5:0] && pool_req_count == t.cnt,
            "R3/R6 request", {pool_req_kind, pool_req_id, pool_req_count},
            {(t.code == 3'd4), t.pool[5:0], t.cnt});
      pool_req_ready = 1'b1;
      @(negedge clk); pool_req_ready = 1'b0;
      k  = (t.avail < t.cnt) ? int'(t.avail) : int'(t.cnt);
      nb = (t.err || t.code == 3'd4 || k == 0) ? 1 : k;
      for (int b = 0; b < nb; b++) begin
        if (b == nb - 1) begin
          rd(ph, 3'd0);
          check(rd_verb == 8'h00, "R12 busy verb", rd_verb, 0);
        end
        pool_rsp_valid = 1'b1;
        pool_rsp_err   = t.err;
        pool_rsp_none  = !t.err && t.code != 3'd4 && k == 0;
        pool_rsp_last  = (b == nb - 1);
        pool_rsp_data  = (t.code == 3'd4) ? 64'(t.avail)
                         : {8'hD0, 40'h0, t.pool, 8'(b)};
        while (!pool_rsp_ready) @(negedge clk);
        @(negedge clk);
      end
      pool_rsp_valid = 1'b0; pool_rsp_last = 1'b0;
      pool_rsp_err = 1'b0; pool_rsp_none = 1'b0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (pool_req_valid) found = 1'b1;
      end
      check(!found, "R7 no request", found, 0);
    end
    xv = {ph, t.xcode, t.xcnt};
    for (int i = 0; i < 30; i++) begin
      rd(ph, 3'd0);
      if (rd_verb != 8'h00) break;
      @(negedge clk);
    end
    check(rd_verb == xv, "R4-R9 verb", rd_verb, xv);
    check(rd_pool == t.pool, "R11 pool echo", rd_pool, t.pool);
    rd(~ph, 3'd0);
    check(rd_verb == 8'h00, "R10 other zero", rd_verb, 0);
    if (t.xcode == 3'd1) begin
      for (int s = 0; s < int'(t.xcnt); s++) begin
        rd(ph, 3'(s));
        check(rd_desc == {8'hD0, 40'h0, t.pool, 8'(s)}, "R4 descriptor",
              rd_desc, {8'hD0, 40'h0, t.pool, 8'(s)});
      end
    end
    if (t.xcode == 3'd4) begin
      rd(ph, 3'd0);
      check(rd_desc == 64'(t.avail), "R6 query data", rd_desc, 64'(t.avail));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic ph;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, 3'd0); check(rd_verb == 8'h00, "R1 reg0 verb", rd_verb, 0);
    rd(1'b1, 3'd0); check(rd_verb == 8'h00, "R1 reg1 verb", rd_verb, 0);
    check(cmd_verb_rd == 8'h80, "R1 cmd verb", cmd_verb_rd, 8'h80);
    check(!pool_req_valid, "R1 no request", pool_req_valid, 0);
    // R2 wrong phase after reset
    write_cmd(8'h91, 8'd3);
    quiet(8, "R2 wrong phase", 8'h00, 8'h00);
    // table walk, R9 alternation from register 0
    ph = 1'b0;
    for (int v = 0; v < 12; v++) begin
      write_cmd({ph, TBL[v].code, TBL[v].cnt}, TBL[v].pool);
      run_vec(TBL[v], ph);
      ph = ~ph;
    end
    // R2 stale phase repeated: last command used phase 1
    write_cmd({1'b1, TBL[11].code, TBL[11].cnt}, TBL[11].pool);
    quiet(8, "R2 stale phase", 8'h00, {1'b1, 3'd1, 4'd5});
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule